// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Repeat Modes

This block decides when a real-time clock alarm goes off. Once per second, on an update strobe from the timekeeping counters, it compares the current BCD seconds, minutes, hours and day-of-month against four programmed alarm bytes. The top bit of each alarm byte is a repeat bit. Together the four repeat bits choose which time fields must match, so the alarm can fire every second, minute, hour, day or month.

A match sets a sticky alarm flag. The flag drives an active-low interrupt request when the flag interrupt enable is set. While the system runs from its back-up battery, the request also needs the back-up interrupt enable. The flag is set whatever the enables are. Software clears the flag, and with it the request, by reading the flags location. The read strobe must be held for a minimum number of consecutive clocks before the clear takes effect. A match in the same cycle as a clear wins.

The time counters, the bus decode and the registers that hold the enables are outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: While reset is asserted, and on the clock after it, `alarm_flag` is 0 and `irq_n` is 1.
- R2: Repeat code {date[7],hour[7],min[7],sec[7]} = 4'b1111 sets `alarm_flag` on every update strobe, whatever the time fields hold.
- R3: Code 4'b1110 compares only the seconds field (bits 6:0). A differing seconds value does not set the flag.
- R4: Code 4'b1100 compares seconds and minutes. A minutes mismatch alone prevents the set.
- R5: Code 4'b1000 compares seconds, minutes and hours (bits 5:0 of the hours field compared as bits 6:0). An hours mismatch alone prevents the set.
- R6: Code 4'b0000 compares all four fields. A date mismatch alone prevents the set.
- R7: Any repeat code other than the five listed above behaves as 4'b1111 and sets the flag on every strobe.
- R8: An alarm date byte of 8'h00 with repeat code 4'b0000 disables the alarm, even when the current time equals the alarm bytes.
- R9: The comparison takes effect only on a cycle with `sec_tick` high. `alarm_flag` rises on the clock edge that samples the strobe, and never without a strobe.
- R10: With `on_battery` low, `irq_n` is low exactly when `alarm_flag` and `flag_irq_en` are both 1.
- R11: With `on_battery` high, `irq_n` is low only when `alarm_flag`, `flag_irq_en` and `backup_irq_en` are all 1. The flag is still set with the enables at 0.
- R12: A `flag_rd` pulse of one clock leaves the flag set. Holding `flag_rd` for RD_HOLD (default 2) consecutive clocks clears the flag on the edge that samples the last of them.
- R13: If a set and a clear fall on the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-clock once-per-second update strobe |
| cur_sec | input | 8 | Current seconds, BCD in bits 6:0 |
| cur_min | input | 8 | Current minutes, BCD in bits 6:0 |
| cur_hour | input | 8 | Current hours, BCD in bits 5:0 |
| cur_date | input | 8 | Current day of month, BCD in bits 5:0 |
| alm_sec | input | 8 | Alarm seconds, repeat bit 1 in bit 7 |
| alm_min | input | 8 | Alarm minutes, repeat bit 2 in bit 7 |
| alm_hour | input | 8 | Alarm hours, repeat bit 3 in bit 7 |
| alm_date | input | 8 | Alarm date, repeat bit 4 in bit 7 |
| flag_irq_en | input | 1 | Interrupt enable for the alarm flag |
| backup_irq_en | input | 1 | Additional enable needed while on battery |
| on_battery | input | 1 | High while running from back-up power |
| flag_rd | input | 1 | Flags-location read strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench fixes one current time and walks the repeat codes. For each code it applies a time that differs from the alarm in exactly the first field the code adds to the comparison, then the exact match. This separates each mask from its neighbours: a decoder that compares one field too many or too few gives the wrong flag on one of the two strobes. An illegal code applied with every field mismatched separates the fall-back from a full compare. An all-zero alarm applied against an all-zero time separates the disable rule from a genuine month match. The enable combinations are swept with battery power on and off. Read strobes of one and two clocks, and a two-clock read that coincides with a strobe, separate the hold rule and the set-over-clear priority.

// File: rtl/rtcalm_pkg.sv
// Shared constants and types for the alarm comparator.
// Assumes the four alarm fields are ordered seconds, minutes, hours, date.
package rtcalm_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int FIELD_W    = 8;
    localparam int VALUE_W    = FIELD_W - 1;

    typedef logic [NUM_FIELDS-1:0] field_mask_t;
    typedef logic [FIELD_W-1:0]    field_t;

    // Repeat codes, written {date, hour, min, sec} repeat bits
    localparam logic [3:0] RPT_SECOND = 4'b1111;
    localparam logic [3:0] RPT_MINUTE = 4'b1110;
    localparam logic [3:0] RPT_HOUR   = 4'b1100;
    localparam logic [3:0] RPT_DAY    = 4'b1000;
    localparam logic [3:0] RPT_MONTH  = 4'b0000;
endpackage

// File: rtl/rtcalm_repeat_dec.sv
// Turns the four repeat bits into a per-field compare mask.
// Codes outside the five legal ones compare nothing, so they fire every second.
// An alarm date of zero with code 0000 disarms the alarm.
module rtcalm_repeat_dec
    import rtcalm_pkg::*;
(
    input  logic [3:0]         rpt_code,
    input  logic [VALUE_W-1:0] date_value,
    output field_mask_t        use_mask,
    output logic               armed
);
    // Map repeat code to the set of fields that must match
    always_comb begin
        unique case (rpt_code)
            RPT_SECOND: use_mask = 4'b0000;
            RPT_MINUTE: use_mask = 4'b0001;
            RPT_HOUR:   use_mask = 4'b0011;
            RPT_DAY:    use_mask = 4'b0111;
            RPT_MONTH:  use_mask = 4'b1111;
            default:    use_mask = 4'b0000;
        endcase
    end

    // Disarm on a zero date with month repeat
    always_comb begin
        armed = !((rpt_code == RPT_MONTH) && (date_value == '0));
    end
endmodule

// File: rtl/rtcalm_field_cmp.sv
// Compares each current time field against its alarm value.
// Fields outside the mask count as matching; bit 7 of the alarm bytes is excluded.
module rtcalm_field_cmp
    import rtcalm_pkg::*;
(
    input  field_t [NUM_FIELDS-1:0] cur_fields,
    input  field_t [NUM_FIELDS-1:0] alm_fields,
    input  field_mask_t             use_mask,
    input  logic                    armed,
    output logic                    hit
);
    field_mask_t field_ok;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        // Per-field equality, forced true when the field is not compared
        always_comb begin
            field_ok[i] = !use_mask[i] ||
                          (cur_fields[i][VALUE_W-1:0] == alm_fields[i][VALUE_W-1:0]);
        end
    end

    // All compared fields equal and the alarm is armed
    always_comb begin
        hit = armed && (&field_ok);
    end
endmodule

// File: rtl/rtcalm_flag_ctl.sv
// Holds the sticky alarm flag and forms the active-low interrupt request.
// Assumes sec_tick is a one-clock strobe. A clear needs flag_rd held for RD_HOLD
// consecutive clocks; a set on the same edge wins.
module rtcalm_flag_ctl #(
    parameter int RD_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic flag_rd,
    input  logic flag_irq_en,
    input  logic backup_irq_en,
    input  logic on_battery,
    output logic alarm_flag,
    output logic irq_n
);
    localparam int CNT_W = $clog2(RD_HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_HOLD - 1);

    logic [CNT_W-1:0] rd_run;
    logic             clr_req;

    // Clear once the read has been held long enough
    always_comb begin
        clr_req = flag_rd && (rd_run >= CNT_LAST);
    end

    // Count consecutive read cycles, saturating at the hold length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run <= '0;
        end else if (!flag_rd) begin
            rd_run <= '0;
        end else if (rd_run < CNT_LAST) begin
            rd_run <= rd_run + 1'b1;
        end
    end

    // Sticky flag, set takes priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
        end else if (set_req) begin
            alarm_flag <= 1'b1;
        end else if (clr_req) begin
            alarm_flag <= 1'b0;
        end
    end

    // Interrupt request gated by the enables and the power source
    always_comb begin
        irq_n = !(alarm_flag && flag_irq_en && (!on_battery || backup_irq_en));
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Top of the alarm comparator: repeat decode, field compare, flag and request.
// Evaluates the compare only on sec_tick; the flag updates on that same edge.
module rtc_alarm_match
    import rtcalm_pkg::*;
#(
    parameter int RD_HOLD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_date,
    input  logic       flag_irq_en,
    input  logic       backup_irq_en,
    input  logic       on_battery,
    input  logic       flag_rd,
    output logic       alarm_flag,
    output logic       irq_n
);
    field_t [NUM_FIELDS-1:0] cur_fields;
    field_t [NUM_FIELDS-1:0] alm_fields;
    logic   [3:0]            rpt_code;
    field_mask_t             use_mask;
    logic                    armed;
    logic                    hit;
    logic                    set_req;

    // Gather fields in seconds-to-date order and pull out the repeat bits
    always_comb begin
        cur_fields = {cur_date, cur_hour, cur_min, cur_sec};
        alm_fields = {alm_date, alm_hour, alm_min, alm_sec};
        rpt_code   = {alm_date[FIELD_W-1], alm_hour[FIELD_W-1],
                      alm_min[FIELD_W-1],  alm_sec[FIELD_W-1]};
    end

    rtcalm_repeat_dec u_dec (
        .rpt_code   (rpt_code),
        .date_value (alm_date[VALUE_W-1:0]),
        .use_mask   (use_mask),
        .armed      (armed)
    );

    rtcalm_field_cmp u_cmp (
        .cur_fields (cur_fields),
        .alm_fields (alm_fields),
        .use_mask   (use_mask),
        .armed      (armed),
        .hit        (hit)
    );

    // Qualify the compare with the update strobe
    always_comb begin
        set_req = sec_tick && hit;
    end

    rtcalm_flag_ctl #(.RD_HOLD(RD_HOLD)) u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_req       (set_req),
        .flag_rd       (flag_rd),
        .flag_irq_en   (flag_irq_en),
        .backup_irq_en (backup_irq_en),
        .on_battery    (on_battery),
        .alarm_flag    (alarm_flag),
        .irq_n         (irq_n)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Property checker for rtc_alarm_match, attached with bind.
// Observes ports only; assumes RD_HOLD is at least 2.
module rtc_alarm_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic [7:0] alm_sec,
    input logic [7:0] alm_min,
    input logic [7:0] alm_hour,
    input logic [7:0] alm_date,
    input logic       flag_irq_en,
    input logic       backup_irq_en,
    input logic       on_battery,
    input logic       flag_rd,
    input logic       alarm_flag,
    input logic       irq_n
);
    logic every_sec;
    always_comb begin
        every_sec = alm_sec[7] && alm_min[7] && alm_hour[7] && alm_date[7];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!alarm_flag && irq_n));

    // R9
    no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !alarm_flag) |=> !alarm_flag);

    // R2
    every_second_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && every_sec) |=> alarm_flag);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (alarm_flag && flag_irq_en));

    // R11
    battery_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && !backup_irq_en) |-> irq_n);

    // R12
    short_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && flag_rd && !$past(flag_rd)) |=> alarm_flag);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .alm_sec       (alm_sec),
    .alm_min       (alm_min),
    .alm_hour      (alm_hour),
    .alm_date      (alm_date),
    .flag_irq_en   (flag_irq_en),
    .backup_irq_en (backup_irq_en),
    .on_battery    (on_battery),
    .flag_rd       (flag_rd),
    .alarm_flag    (alarm_flag),
    .irq_n         (irq_n)
);

// File: tb/rtc_alarm_match_bench.sv
// Directed bench for rtc_alarm_match: one task per scenario, each checking itself.
module rtc_alarm_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = 8'h56, cur_min = 8'h34, cur_hour = 8'h12, cur_date = 8'h15;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00, alm_date = 8'h00;
    logic       flag_irq_en = 1'b0, backup_irq_en = 1'b0, on_battery = 1'b0;
    logic       flag_rd = 1'b0;
    logic       alarm_flag, irq_n;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    rtc_alarm_match u_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
        .flag_irq_en(flag_irq_en), .backup_irq_en(backup_irq_en), .on_battery(on_battery),
        .flag_rd(flag_rd), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Alarm bytes with repeat code {date,hour,min,sec}
    task automatic set_alarm(input logic [3:0] code, input logic [6:0] s,
                             input logic [6:0] m, input logic [6:0] h, input logic [6:0] d);
        @(negedge clk);
        alm_sec  = {code[0], s};
        alm_min  = {code[1], m};
        alm_hour = {code[2], h};
        alm_date = {code[3], d};
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    endtask

    // One strobe; flag visible after the sampling edge
    task automatic tick_once();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic read_flags(input int cycles);
        @(negedge clk); flag_rd = 1'b1;
        for (int i = 1; i < cycles; i++) @(negedge clk);
        @(negedge clk); flag_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flag in reset", alarm_flag, 1'b0);
        check("R1 irq in reset", irq_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        check("R1 flag after reset", alarm_flag, 1'b0);
    endtask

    task automatic t_every_second();
        set_alarm(4'b1111, 7'h00, 7'h00, 7'h00, 7'h00);
        tick_once();
        check("R2 every second", alarm_flag, 1'b1);
        read_flags(2);
        check("R12 two-clock read clears", alarm_flag, 1'b0);
    endtask

    task automatic t_minute();
        set_alarm(4'b1110, 7'h56, 7'h00, 7'h00, 7'h01);
        set_time(8'h57, 8'h34, 8'h12, 8'h15);
        tick_once();
        check("R3 seconds mismatch", alarm_flag, 1'b0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15);
        tick_once();
        check("R3 seconds match", alarm_flag, 1'b1);
        read_flags(2);
    endtask

    task automatic t_hour();
        set_alarm(4'b1100, 7'h56, 7'h34, 7'h00, 7'h01);
        set_time(8'h56, 8'h35, 8'h12, 8'h15);
        tick_once();
        check("R4 minutes mismatch", alarm_flag, 1'b0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15);
        tick_once();
        check("R4 sec+min match", alarm_flag, 1'b1);
        read_flags(2);
    endtask

    task automatic t_day();
        set_alarm(4'b1000, 7'h56, 7'h34, 7'h12, 7'h01);
        set_time(8'h56, 8'h34, 8'h13, 8'h15);
        tick_once();
        check("R5 hours mismatch", alarm_flag, 1'b0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15);
        tick_once();
        check("R5 hms match", alarm_flag, 1'b1);
        read_flags(2);
    endtask

    task automatic t_month();
        set_alarm(4'b0000, 7'h56, 7'h34, 7'h12, 7'h15);
        set_time(8'h56, 8'h34, 8'h12, 8'h16);
        tick_once();
        check("R6 date mismatch", alarm_flag, 1'b0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15);
        tick_once();
        check("R6 full match", alarm_flag, 1'b1);
        read_flags(2);
    endtask

    task automatic t_illegal();
        set_alarm(4'b0101, 7'h01, 7'h02, 7'h03, 7'h04);
        tick_once();
        check("R7 illegal code fires", alarm_flag, 1'b1);
        read_flags(2);
    endtask

    task automatic t_disabled();
        set_alarm(4'b0000, 7'h00, 7'h00, 7'h00, 7'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h00);
        tick_once();
        check("R8 zero alarm disabled", alarm_flag, 1'b0);
        set_time(8'h56, 8'h34, 8'h12, 8'h15);
    endtask

    task automatic t_no_tick();
        set_alarm(4'b1111, 7'h00, 7'h00, 7'h00, 7'h00);
        repeat (5) @(negedge clk);
        check("R9 no strobe no flag", alarm_flag, 1'b0);
        @(negedge clk); sec_tick = 1'b1;
        @(posedge clk); #1;
        check("R9 flag on sampling edge", alarm_flag, 1'b1);
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic t_irq_mains();
        @(negedge clk); on_battery = 1'b0; flag_irq_en = 1'b0; backup_irq_en = 1'b0;
        #1;
        check("R10 flag set, AFE off", irq_n, 1'b1);
        @(negedge clk); flag_irq_en = 1'b1;
        #1;
        check("R10 flag set, AFE on", irq_n, 1'b0);
    endtask

    task automatic t_irq_battery();
        @(negedge clk); on_battery = 1'b1; backup_irq_en = 1'b0;
        #1;
        check("R11 battery, ABE off", irq_n, 1'b1);
        check("R11 flag kept", alarm_flag, 1'b1);
        @(negedge clk); backup_irq_en = 1'b1;
        #1;
        check("R11 battery, both on", irq_n, 1'b0);
        @(negedge clk); flag_irq_en = 1'b0;
        #1;
        check("R11 battery, AFE off", irq_n, 1'b1);
        @(negedge clk); on_battery = 1'b0; flag_irq_en = 1'b1; backup_irq_en = 1'b0;
    endtask

    task automatic t_read_hold();
        read_flags(1);
        check("R12 one-clock read keeps", alarm_flag, 1'b1);
        read_flags(2);
        check("R12 two-clock read clears", alarm_flag, 1'b0);
        check("R10 irq released", irq_n, 1'b1);
    endtask

    task automatic t_priority();
        tick_once();
        check("R13 setup flag", alarm_flag, 1'b1);
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; flag_rd = 1'b0;
        check("R13 set beats clear", alarm_flag, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_every_second();
        t_minute();
        t_hour();
        t_day();
        t_month();
        t_illegal();
        t_disabled();
        t_no_tick();
        t_irq_mains();
        t_irq_battery();
        t_read_hold();
        t_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule